// File: doc/BRIEF.md
# Static Memory Strobe Generator

This block runs one chip-select window of an asynchronous static-memory bus of the kind used to reach a CompactFlash card wired in True-IDE mode. A host issues a request with a level `host_req`, a direction flag, a register address and write data. The block then plays out one bus cycle: an active-low chip select, a read or write strobe, a driven or sampled data bus, and finally a one-clock `host_ack`. The strobe timing arrives as compact split-bit fields that the block expands itself. Reads and writes use the same setup, pulse and cycle counts.

Every request latches its timing, mode bits, address and data when it is accepted, so later changes on those inputs do not affect a cycle that is already running. In ready-wait mode an external ready line, passed through a two-flop synchronizer, can stretch the strobe pulse. After a read, a programmable number of float clocks lets the device release the data bus before the next cycle can start. The data width is chosen for each access: 8 bits for register traffic and 16 bits for data-register transfers.

The controller has six states. `ST_IDLE` waits for a request. `ST_SETUP` covers the clocks before the strobe. `ST_PULSE` is the strobe-low phase. `ST_RECOVER` holds the remainder of the cycle. `ST_DONE` is the acknowledge clock. `ST_FLOAT` holds the bus idle after a read. The transitions are:
- IDLE to SETUP, or straight to PULSE when the setup count is zero, on a request.
- SETUP to PULSE, and PULSE to RECOVER, as the clock index crosses the phase limits.
- Any of SETUP, PULSE or RECOVER to DONE on the last cycle clock.
- DONE to FLOAT after a read with a non-zero float count, otherwise DONE to IDLE.
- FLOAT to IDLE when the float count runs out.

Top module: `smc_strobe_gen`

## Requirements
- R1: The setup count is S = 128*setup_enc[5] + setup_enc[4:0]. The active strobe first goes low S clocks after the first clock of the access, where the first access clock is index 0.
- R2: The pulse count is P = 256*pulse_enc[6] + pulse_enc[5:0], and a value of 0 is taken as 1. The strobe stays low for exactly P clocks when not stretched. `bus_rd_n` is used for reads and `bus_wr_n` for writes, and the other strobe stays high throughout.
- R3: The raw cycle count is C = 256*cycle_enc[8:7] + cycle_enc[6:0]. An access lasts max(C, S+P) clocks plus any stretch clocks. `host_ack` is high for exactly one clock, the clock right after the last access clock. In that clock chip select and both strobes are high.
- R4: The chip-select count is K = 256*cs_enc[6] + cs_enc[5:0], and a value of 0 is taken as 1. `bus_cs_n` is low from access clock 0 for min(K, access length) clocks. If chip select is still low when the strobe begins, the stretch clocks are added to its low time.
- R5: With ready-wait latched as 1, each strobe clock in which the synchronized ready is low freezes the cycle. If `bus_ready` was already low and rises during strobe clock W, the strobe stays low for P+W+1 clocks, because of the two-flop synchronizer.
- R6: With ready-wait latched as 0, `bus_ready` is ignored. A low ready changes neither the strobe width nor the access length.
- R7: Read data is captured from `bus_dq_in` at the end of the last strobe clock. It is presented on `host_rdata` in the acknowledge clock. For an 8-bit access (`cfg_wide`=0) the upper byte reads as zero.
- R8: During every clock of a write access, `bus_dq_out` equals the latched write data. `bus_dq_oe` is 2'b11 for a 16-bit access and 2'b01 for an 8-bit access. At all other times, and during reads, `bus_dq_oe` is 2'b00.
- R9: With `host_req` held high, the next access starts F+2 clocks after the acknowledge clock of a read, where F is `cfg_float` (0 to 15). After a write or a read with F=0 it starts 2 clocks after the acknowledge clock. From idle it starts in the clock after `host_req` is first seen.
- R10: While `rst_n` is low and after its release, chip select and both strobes are high, `host_ack` is 0 and `bus_dq_oe` is 2'b00.
- R11: Timing fields, mode bits, address, direction and write data are sampled when the request is accepted. Changing them during an access has no effect on that access.
- R12: `bus_addr` carries the latched request address during every strobe clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_setup | input | 6 | Encoded setup count |
| cfg_pulse | input | 7 | Encoded strobe pulse count |
| cfg_cycle | input | 9 | Encoded cycle count |
| cfg_cs_pulse | input | 7 | Encoded chip-select low count |
| cfg_float | input | 4 | Idle clocks after a read |
| cfg_ready_wait | input | 1 | 1: honour bus_ready during the strobe |
| cfg_wide | input | 1 | 1: 16-bit access, 0: 8-bit access |
| host_req | input | 1 | Access request, held until acknowledged |
| host_write | input | 1 | 1: write, 0: read |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | DATA_W | Write data |
| host_ack | output | 1 | One-clock completion pulse |
| host_rdata | output | DATA_W | Captured read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_dq_out | output | DATA_W | Write data toward the bus |
| bus_dq_oe | output | 2 | Per-byte-lane output enable |
| bus_dq_in | input | DATA_W | Data from the bus |
| bus_ready | input | 1 | Asynchronous device ready |

## Verification
Most wrong internal states show up within the same access. A bad expansion of a field, or a wrong clock index, moves the strobe edge, changes the strobe width or changes the access length, and the acknowledge clock then lands at the wrong point. A stuck stall, or a stall that never clears, either stretches the strobe by the wrong amount or hangs the cycle until the watchdog fires. A float counter or latched-direction error does not show until the next request, where the start delay after the acknowledge is wrong. A capture-timing slip shows as wrong `host_rdata` in the acknowledge clock, because the bench changes the bus data on every clock.

// File: rtl/smc_strobe_pkg.sv
package smc_strobe_pkg;

    // Encoded field widths and the split points of each encoding
    localparam int SETUP_ENC_W = 6;
    localparam int PULSE_ENC_W = 7;
    localparam int CYCLE_ENC_W = 9;
    localparam int FLOAT_W     = 4;
    localparam int SETUP_LO_W  = 5;
    localparam int PULSE_LO_W  = 6;
    localparam int CYCLE_LO_W  = 7;

    // Counter wide enough for the largest expanded cycle (895)
    localparam int CNT_W = 10;

    // Byte lanes on the data bus
    localparam int LANES = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_RECOVER,
        ST_DONE,
        ST_FLOAT
    } smc_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;   // clocks before the strobe
        logic [CNT_W-1:0] pulse;   // strobe clocks, at least 1
        logic [CNT_W-1:0] cycle;   // total clocks, at least setup+pulse
        logic [CNT_W-1:0] cs_len;  // chip-select clocks, at least 1
    } smc_timing_t;

endpackage

// File: rtl/smc_field_expand.sv
module smc_field_expand
    import smc_strobe_pkg::*;
(
    input  logic [SETUP_ENC_W-1:0] setup_enc,
    input  logic [PULSE_ENC_W-1:0] pulse_enc,
    input  logic [CYCLE_ENC_W-1:0] cycle_enc,
    input  logic [PULSE_ENC_W-1:0] cs_enc,
    output smc_timing_t            timing
);

    localparam int SETUP_HI_POS = 7;   // weight 128
    localparam int PULSE_HI_POS = 8;   // weight 256
    localparam int CYCLE_HI_POS = 8;   // weight 256 and 512

    logic [CNT_W-1:0] setup_raw;
    logic [CNT_W-1:0] pulse_raw;
    logic [CNT_W-1:0] cycle_raw;
    logic [CNT_W-1:0] cs_raw;
    logic [CNT_W-1:0] pulse_eff;
    logic [CNT_W-1:0] active_sum;

    always_comb begin
        setup_raw = '0;
        setup_raw[SETUP_LO_W-1:0] = setup_enc[SETUP_LO_W-1:0];
        setup_raw[SETUP_HI_POS]   = setup_enc[SETUP_ENC_W-1];

        pulse_raw = '0;
        pulse_raw[PULSE_LO_W-1:0] = pulse_enc[PULSE_LO_W-1:0];
        pulse_raw[PULSE_HI_POS]   = pulse_enc[PULSE_ENC_W-1];

        cs_raw = '0;
        cs_raw[PULSE_LO_W-1:0] = cs_enc[PULSE_LO_W-1:0];
        cs_raw[PULSE_HI_POS]   = cs_enc[PULSE_ENC_W-1];

        cycle_raw = '0;
        cycle_raw[CYCLE_LO_W-1:0] = cycle_enc[CYCLE_LO_W-1:0];
        cycle_raw[CYCLE_HI_POS +: 2] = cycle_enc[CYCLE_ENC_W-1 -: 2];

        pulse_eff  = (pulse_raw == '0) ? CNT_W'(1) : pulse_raw;
        active_sum = setup_raw + pulse_eff;

        timing.setup  = setup_raw;
        timing.pulse  = pulse_eff;
        timing.cycle  = (cycle_raw > active_sum) ? cycle_raw : active_sum;
        timing.cs_len = (cs_raw == '0) ? CNT_W'(1) : cs_raw;
    end

endmodule

// File: rtl/smc_ready_sync.sv
module smc_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/smc_strobe_gen.sv
module smc_strobe_gen
    import smc_strobe_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SETUP_ENC_W-1:0] cfg_setup,
    input  logic [PULSE_ENC_W-1:0] cfg_pulse,
    input  logic [CYCLE_ENC_W-1:0] cfg_cycle,
    input  logic [PULSE_ENC_W-1:0] cfg_cs_pulse,
    input  logic [FLOAT_W-1:0]     cfg_float,
    input  logic                   cfg_ready_wait,
    input  logic                   cfg_wide,
    input  logic                   host_req,
    input  logic                   host_write,
    input  logic [ADDR_W-1:0]      host_addr,
    input  logic [DATA_W-1:0]      host_wdata,
    output logic                   host_ack,
    output logic [DATA_W-1:0]      host_rdata,
    output logic                   bus_cs_n,
    output logic                   bus_rd_n,
    output logic                   bus_wr_n,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [DATA_W-1:0]      bus_dq_out,
    output logic [LANES-1:0]       bus_dq_oe,
    input  logic [DATA_W-1:0]      bus_dq_in,
    input  logic                   bus_ready
);

    localparam int LANE_W = DATA_W / LANES;

    // Decoded timing of the incoming request
    smc_timing_t req_tm;

    smc_field_expand u_expand (
        .setup_enc (cfg_setup),
        .pulse_enc (cfg_pulse),
        .cycle_enc (cfg_cycle),
        .cs_enc    (cfg_cs_pulse),
        .timing    (req_tm)
    );

    logic rdy_s;

    smc_ready_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_ready),
        .sync_out (rdy_s)
    );

    // Control state
    smc_state_e        state_q, state_n;
    logic [CNT_W-1:0]  t_q, t_n;
    logic [FLOAT_W-1:0] fl_q, fl_n;

    // Per-access latched context
    smc_timing_t        tm_q;
    logic [FLOAT_W-1:0] float_cfg_q;
    logic               wr_q;
    logic               wide_q;
    logic               wait_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rdata_q;

    logic               accept;
    logic               in_access;
    logic               stall_w;
    logic               last_clk;
    logic               strobe_end;
    logic               rd_capture;
    logic [CNT_W-1:0]   t_inc;
    logic [LANES-1:0]   lane_en;
    logic [DATA_W-1:0]  rd_masked;

    function automatic smc_state_e phase_of(input logic [CNT_W-1:0] t,
                                            input smc_timing_t tm);
        if (t < tm.setup)                 return ST_SETUP;
        else if (t < tm.setup + tm.pulse) return ST_PULSE;
        else                              return ST_RECOVER;
    endfunction

    assign accept     = (state_q == ST_IDLE) && host_req;
    assign in_access  = (state_q == ST_SETUP) || (state_q == ST_PULSE) ||
                        (state_q == ST_RECOVER);
    assign stall_w    = (state_q == ST_PULSE) && wait_q && !rdy_s;
    assign last_clk   = (t_q == tm_q.cycle - 1'b1);
    assign strobe_end = (t_q == tm_q.setup + tm_q.pulse - 1'b1);
    assign rd_capture = (state_q == ST_PULSE) && !stall_w && !wr_q && strobe_end;
    assign t_inc      = t_q + 1'b1;

    // Byte-lane enables: lane 0 always, upper lanes only for wide accesses
    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            if (ln == 0) begin : g_base
                assign lane_en[ln] = 1'b1;
            end else begin : g_upper
                assign lane_en[ln] = wide_q;
            end
            assign rd_masked[ln*LANE_W +: LANE_W] =
                lane_en[ln] ? bus_dq_in[ln*LANE_W +: LANE_W] : '0;
        end
    endgenerate

    // Next-state logic
    always_comb begin
        state_n = state_q;
        t_n     = t_q;
        fl_n    = fl_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    t_n     = '0;
                    state_n = (req_tm.setup == '0) ? ST_PULSE : ST_SETUP;
                end
            end
            ST_SETUP, ST_PULSE, ST_RECOVER: begin
                if (!stall_w) begin
                    if (last_clk) begin
                        state_n = ST_DONE;
                    end else begin
                        t_n     = t_inc;
                        state_n = phase_of(t_inc, tm_q);
                    end
                end
            end
            ST_DONE: begin
                if (!wr_q && (float_cfg_q != '0)) begin
                    state_n = ST_FLOAT;
                    fl_n    = float_cfg_q;
                end else begin
                    state_n = ST_IDLE;
                end
            end
            ST_FLOAT: begin
                fl_n = fl_q - 1'b1;
                if (fl_q == FLOAT_W'(1)) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            t_q     <= '0;
            fl_q    <= '0;
        end else begin
            state_q <= state_n;
            t_q     <= t_n;
            fl_q    <= fl_n;
        end
    end

    // Request context and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q        <= '0;
            float_cfg_q <= '0;
            wr_q        <= 1'b0;
            wide_q      <= 1'b0;
            wait_q      <= 1'b0;
            addr_q      <= '0;
            wdata_q     <= '0;
            rdata_q     <= '0;
        end else begin
            if (accept) begin
                tm_q        <= req_tm;
                float_cfg_q <= cfg_float;
                wr_q        <= host_write;
                wide_q      <= cfg_wide;
                wait_q      <= cfg_ready_wait;
                addr_q      <= host_addr;
                wdata_q     <= host_wdata;
            end
            if (rd_capture) rdata_q <= rd_masked;
        end
    end

    // Outputs
    always_comb begin
        host_ack   = (state_q == ST_DONE);
        host_rdata = rdata_q;
        bus_cs_n   = !(in_access && (t_q < tm_q.cs_len));
        bus_rd_n   = !((state_q == ST_PULSE) && !wr_q);
        bus_wr_n   = !((state_q == ST_PULSE) && wr_q);
        bus_addr   = addr_q;
        bus_dq_out = wdata_q;
        bus_dq_oe  = (in_access && wr_q) ? lane_en : '0;
    end

endmodule

// File: rtl/smc_strobe_gen_chk.sv
module smc_strobe_gen_chk #(
    parameter int LANES_P = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_ack,
    input logic               bus_cs_n,
    input logic               bus_rd_n,
    input logic               bus_wr_n,
    input logic [LANES_P-1:0] bus_dq_oe,
    input logic               stall
);

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    // R3
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R3
    ack_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> (bus_cs_n && bus_rd_n && bus_wr_n));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !(bus_rd_n && bus_wr_n)) |=> ($stable(bus_rd_n) && $stable(bus_wr_n)));

    // R4
    stall_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !bus_cs_n) |=> !bus_cs_n);

    // R8
    oe_read_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dq_oe != '0) |-> bus_rd_n);

endmodule

bind smc_strobe_gen smc_strobe_gen_chk #(.LANES_P(smc_strobe_pkg::LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_ack  (host_ack),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_dq_oe (bus_dq_oe),
    .stall     (stall_w)
);

// File: tb/smc_strobe_gen_test.sv
module smc_strobe_gen_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  cfg_setup;
    logic [6:0]  cfg_pulse;
    logic [8:0]  cfg_cycle;
    logic [6:0]  cfg_cs_pulse;
    logic [3:0]  cfg_float;
    logic        cfg_ready_wait;
    logic        cfg_wide;
    logic        host_req;
    logic        host_write;
    logic [2:0]  host_addr;
    logic [15:0] host_wdata;
    logic        host_ack;
    logic [15:0] host_rdata;
    logic        bus_cs_n, bus_rd_n, bus_wr_n;
    logic [2:0]  bus_addr;
    logic [15:0] bus_dq_out;
    logic [1:0]  bus_dq_oe;
    logic [15:0] bus_dq_in;
    logic        bus_ready;

    int checks = 0;
    int fails  = 0;
    int exp_gap = 1;

    always #2.5 clk = ~clk;

    smc_strobe_gen uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_cycle(cfg_cycle),
        .cfg_cs_pulse(cfg_cs_pulse), .cfg_float(cfg_float),
        .cfg_ready_wait(cfg_ready_wait), .cfg_wide(cfg_wide),
        .host_req(host_req), .host_write(host_write), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_addr(bus_addr), .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe),
        .bus_dq_in(bus_dq_in), .bus_ready(bus_ready)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int ex_setup(input logic [5:0] s);
        return int'(s[5]) * 128 + int'(s[4:0]);
    endfunction
    function automatic int ex_pulse(input logic [6:0] p);
        return int'(p[6]) * 256 + int'(p[5:0]);
    endfunction
    function automatic int ex_cycle(input logic [8:0] c);
        return int'(c[8:7]) * 256 + int'(c[6:0]);
    endfunction

    task automatic go_idle(input int n);
        host_req = 1'b0;
        repeat (n) @(negedge clk);
        exp_gap = 1;
    endtask

    task automatic do_access(input bit wr, input bit wide, input bit wait_en,
                             input logic [5:0] s, input logic [6:0] p,
                             input logic [8:0] c, input logic [6:0] k,
                             input logic [3:0] f, input logic [2:0] addr,
                             input logic [15:0] wd, input int rel_w, input bit scr);
        int se, pe, ce, ke, stall, cs_exp;
        int n, start_n, acc_len, cs_cnt, st_cnt, st_off;
        int bad_other, bad_addr, bad_wr;
        bit started, done, strobe, other;
        logic [15:0] cand, exp_rd;
        string pre;
        pre = scr ? "R11/" : "";
        se = ex_setup(s);
        pe = (ex_pulse(p) == 0) ? 1 : ex_pulse(p);
        ce = (ex_cycle(c) > se + pe) ? ex_cycle(c) : se + pe;
        ke = (ex_pulse(k) == 0) ? 1 : ex_pulse(k);
        stall = (wait_en && rel_w > 0) ? rel_w + 1 : 0;
        cs_exp = ((ke < ce) ? ke : ce) + ((ke > se) ? stall : 0);

        cfg_setup = s; cfg_pulse = p; cfg_cycle = c; cfg_cs_pulse = k;
        cfg_float = f; cfg_ready_wait = wait_en; cfg_wide = wide;
        host_write = wr; host_addr = addr; host_wdata = wd; host_req = 1'b1;

        n = 0; start_n = 0; acc_len = 0; cs_cnt = 0; st_cnt = 0; st_off = -1;
        bad_other = 0; bad_addr = 0; bad_wr = 0; started = 0; done = 0;
        cand = '0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
            if (host_ack) begin
                done = 1;
                // R3 bus idle in the acknowledge clock
                chk(bus_cs_n && bus_rd_n && bus_wr_n && bus_dq_oe == 2'b00,
                    {pre, "R3 idle at ack"}, {bus_cs_n, bus_rd_n, bus_wr_n}, 7);
            end else begin
                if (!started && !bus_cs_n) begin
                    started = 1;
                    start_n = n;
                end
                if (started) begin
                    acc_len++;
                    if (!bus_cs_n) cs_cnt++;
                    strobe = wr ? !bus_wr_n : !bus_rd_n;
                    other  = wr ? !bus_rd_n : !bus_wr_n;
                    if (other) bad_other++;
                    if (strobe) begin
                        if (st_cnt == 0) st_off = n - start_n;
                        st_cnt++;
                        if (bus_addr != addr) bad_addr++;
                    end
                    if (wr) begin
                        if (bus_dq_oe != {wide, 1'b1} || bus_dq_out != wd) bad_wr++;
                    end else if (bus_dq_oe != 2'b00) bad_wr++;
                    if (rel_w > 0 && strobe && st_cnt == rel_w) bus_ready = 1'b1;
                    bus_dq_in = 16'($urandom);
                    if (strobe && !wr) cand = bus_dq_in;
                    if (scr) begin
                        cfg_setup = 6'($urandom); cfg_pulse = 7'($urandom);
                        cfg_cycle = 9'($urandom); cfg_cs_pulse = 7'($urandom);
                        cfg_float = 4'($urandom); cfg_wide = 1'($urandom);
                        cfg_ready_wait = 1'($urandom); host_write = 1'($urandom);
                        host_addr = 3'($urandom); host_wdata = 16'($urandom);
                    end
                end
            end
        end
        if (!done) chk(1'b0, "R3 access never acknowledged", n, ce);
        // R9 start delay
        chk(start_n == exp_gap, {pre, "R9 start delay"}, start_n, exp_gap);
        // R1 strobe offset
        chk(st_off == se, {pre, "R1 strobe offset"}, st_off, se);
        // R2 / R5 / R6 strobe width
        chk(st_cnt == pe + stall,
            {pre, wait_en ? "R5 strobe width" : "R2/R6 strobe width"}, st_cnt, pe + stall);
        chk(bad_other == 0, {pre, "R2 wrong strobe"}, bad_other, 0);
        // R3 access length
        chk(acc_len == ce + stall, {pre, "R3 access length"}, acc_len, ce + stall);
        // R4 chip select
        chk(cs_cnt == cs_exp, {pre, "R4 chip select low clocks"}, cs_cnt, cs_exp);
        // R12 address
        chk(bad_addr == 0, {pre, "R12 bus address"}, bad_addr, 0);
        // R8 data drive
        chk(bad_wr == 0, {pre, "R8 data drive"}, bad_wr, 0);
        if (!wr) begin
            exp_rd = wide ? cand : {8'h00, cand[7:0]};
            // R7 read capture
            chk(host_rdata == exp_rd, {pre, "R7 read data"}, host_rdata, exp_rd);
        end
        exp_gap = (!wr && f != 0) ? int'(f) + 2 : 2;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; host_req = 1'b0; host_write = 1'b0; host_addr = '0;
        host_wdata = '0; cfg_setup = '0; cfg_pulse = '0; cfg_cycle = '0;
        cfg_cs_pulse = '0; cfg_float = '0; cfg_ready_wait = 1'b0; cfg_wide = 1'b0;
        bus_dq_in = '0; bus_ready = 1'b1;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(bus_cs_n && bus_rd_n && bus_wr_n && !host_ack && bus_dq_oe == 2'b00,
            "R10 in reset", {bus_cs_n, bus_rd_n, bus_wr_n, host_ack}, 14);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bus_cs_n && bus_rd_n && bus_wr_n && !host_ack && bus_dq_oe == 2'b00,
            "R10 after reset", {bus_cs_n, bus_rd_n, bus_wr_n, host_ack}, 14);

        // Directed corners
        do_access(0, 1, 0, 6'd0, 7'd0, 9'd0, 7'd0, 4'd15, 3'd1, 16'h0, 0, 0);
        do_access(1, 1, 0, 6'd2, 7'd3, 9'd8, 7'd8, 4'd9, 3'd2, 16'hA55A, 0, 0);
        do_access(0, 0, 0, 6'h3F, 7'h7F, 9'h1FF, 7'h7F, 4'd0, 3'd7, 16'h0, 0, 0);
        do_access(0, 1, 0, 6'd10, 7'd2, 9'd20, 7'd3, 4'd1, 3'd3, 16'h0, 0, 0);
        do_access(1, 0, 0, 6'd4, 7'd3, 9'd2, 7'd40, 4'd4, 3'd5, 16'h1234, 0, 1);

        bus_ready = 1'b0;
        go_idle(4);
        do_access(0, 1, 1, 6'd3, 7'd4, 9'd12, 7'd20, 4'd2, 3'd6, 16'h0, 5, 0);
        bus_ready = 1'b0;
        go_idle(4);
        do_access(1, 1, 1, 6'd1, 7'd2, 9'd0, 7'd1, 4'd0, 3'd4, 16'hBEEF, 1, 0);
        bus_ready = 1'b0;
        go_idle(4);
        do_access(0, 0, 0, 6'd2, 7'd5, 9'd10, 7'd10, 4'd3, 3'd2, 16'h0, 0, 0);
        bus_ready = 1'b1;
        go_idle(4);

        // Constrained random
        for (int i = 0; i < 150; i++) begin
            logic [5:0] rs;
            logic [6:0] rp, rk;
            logic [8:0] rc;
            rs = {($urandom_range(0, 7) == 0), 5'($urandom)};
            rp = {($urandom_range(0, 7) == 0), 6'($urandom)};
            rk = {($urandom_range(0, 7) == 0), 6'($urandom)};
            rc = {(($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00), 7'($urandom)};
            do_access(1'($urandom), 1'($urandom), 1'($urandom), rs, rp, rc, rk,
                      4'($urandom), 3'($urandom), 16'($urandom), 0, 1'($urandom));
        end
        go_idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule